// File: doc/BRIEF.md
# Flag-Handshake Indirect Configuration Gateway

This block gives a host an indirect path into internal configuration storage through a narrow 32-bit dword register port. The storage is split into numbered address spaces, and each space is a small word memory. The host picks a space through a control register. It places a byte address in an address register and moves data through a data register. The gateway signals that an access has finished by changing the top bit (the flag) of the address register itself, so the host only needs to poll that one register.

A write access loads the data register first. The host then writes the address with the flag set to 1, and the gateway clears the flag once the memory has been updated. A read access writes the address with the flag at 0. The gateway sets the flag once the data register holds the word, and it also replaces the address with the next readable address (4 bytes on). This lets a host scan a whole space by feeding each returned address back in.

Every memory access takes a fixed number of cycles (parameter `LAT`, default 4). Two spaces are built by default: a 16-word scan space with number 0x7 and an 8-word auxiliary space with number 0x2.

The request channel is valid/ready. `req_ready` is held at 1, so the gateway never applies back-pressure, and a request moves on every cycle that `req_valid` is high. Each accepted read returns exactly one response on the next cycle, with `rsp_valid` high for one cycle. The response channel has no ready signal, so the host must take the response in that cycle.

Top module: `cfg_gateway`

## Requirements
- R1: After reset, the control, address and data registers all read 0, and `req_ready` is 1.
- R2: A read request returns `rsp_valid` = 1 with the register value on the next cycle only; every other cycle has `rsp_valid` = 0. Offsets other than 0x04 (control), 0x10 (address) and 0x14 (data) read as 0, and writes to them are dropped.
- R3: A write to control stores the space number from bits [15:0]. When the space is supported (0x7 or 0x2), control reads {3'b001 in [31:29], 1 in bit 28, zeros in [27:16], space number}. For an unsupported space, bits [31:16] read 0.
- R4: Selecting a space clears the flag (bit 31) and the syndrome (bit 30) of the address register. Bits [29:0] then hold the largest byte address of the space, (words−1)×4, or 0 when the space is unsupported.
- R5: An address write with bit 30 set is dropped: no access starts and the address register keeps its value.
- R6: An address write with bit 31 = 1 starts a write access. The flag reads 1 until the edge exactly `LAT` cycles after the request is accepted, and then reads 0. At that point the addressed word (byte address bits [29:2]) holds the data register value.
- R7: An address write with bit 31 = 0 starts a read access. The flag reads 0 until the edge `LAT` cycles after the request is accepted, and then reads 1. At that same edge the data register holds the word and the address field has advanced by 4.
- R8: An access that falls outside the space, or that targets an unsupported space, still completes the flag handshake after `LAT` cycles and sets the syndrome bit. A write of this kind leaves memory unchanged. A read of this kind returns 0 in the data register and still advances the address by 4. The next access that starts clears the syndrome bit.
- R9: While an access is in flight, writes to the control, address and data registers are dropped.
- R10: Each space has its own storage, so a write in one space does not change the other space.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Register request valid |
| req_ready | output | 1 | Request accepted (always 1) |
| req_write | input | 1 | 1 = register write, 0 = register read |
| req_offset | input | 8 | Byte offset of the register |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read response valid, one cycle after the read |
| rsp_rdata | output | 32 | Read response data |

## Verification
The bench polls the address register on every cycle while an access is in flight. This catches a flag that changes one cycle early or one cycle late, and a flag that moves the wrong way for the access type. It runs a scan that chains each returned address into the next read, which exposes an address that fails to advance or advances by the wrong step. It also covers:
- Accesses just past the end of a space, and accesses to an unsupported space. A design without a range check would store into an aliased word or return stale data where it should return 0 and set the syndrome bit.
- Writes sent while an access is in flight, and address writes with bit 30 set. A design that accepted either would change the selected space, the data or the address under a running access.
- Cross-checks between the two spaces, which show storage that is shared or decoded from the wrong space number.

// File: rtl/cfg_gw_pkg.sv
package cfg_gw_pkg;
  localparam logic [7:0] OFS_CTRL = 8'h04;
  localparam logic [7:0] OFS_ADDR = 8'h10;
  localparam logic [7:0] OFS_DATA = 8'h14;

  localparam int ADDR_W   = 30;
  localparam int FLAG_BIT = 31;
  localparam int SYND_BIT = 30;
  localparam int SIZEV_BIT = 28;
  localparam logic [2:0] STATUS_OK = 3'b001;

  function automatic logic [31:0] pack_ctrl(input logic ok, input logic [15:0] space);
    pack_ctrl = ok ? {STATUS_OK, 1'b1, 12'h000, space} : {16'h0000, space};
  endfunction

  function automatic logic [31:0] pack_addr(input logic flag, input logic synd,
                                            input logic [ADDR_W-1:0] a);
    pack_addr = {flag, synd, a};
  endfunction
endpackage

// File: rtl/gw_word_mem.sv
module gw_word_mem #(
  parameter int WORDS = 16,
  parameter int WA_W  = 28
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [WA_W-1:0] word_addr,
  input  logic [31:0]     wdata,
  output logic [31:0]     rdata
);
  localparam int IW = (WORDS > 1) ? $clog2(WORDS) : 1;

  logic [31:0] store [WORDS];
  logic [IW-1:0] idx;

  assign idx   = word_addr[IW-1:0];
  assign rdata = store[idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < WORDS; i++) store[i] <= '0;
    end else if (wr_en) begin
      store[idx] <= wdata;
    end
  end
endmodule

// File: rtl/gw_space_bank.sv
module gw_space_bank
  import cfg_gw_pkg::*;
#(
  parameter int LAT        = 4,
  parameter int SCAN_ID    = 7,
  parameter int SCAN_WORDS = 16,
  parameter int AUX_ID     = 2,
  parameter int AUX_WORDS  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [15:0]       space_i,
  output logic              space_ok,
  output logic [ADDR_W-1:0] space_max,
  input  logic              start,
  input  logic              start_we,
  input  logic [ADDR_W-3:0] start_word,
  input  logic [31:0]       wdata,
  output logic              done,
  output logic              hit,
  output logic [31:0]       rdata
);
  localparam int NSP  = 2;
  localparam int WA_W = ADDR_W - 2;
  localparam int CW   = $clog2(LAT + 1);

  logic [NSP-1:0]    cur_sel, in_rng, txn_sel_q;
  logic [ADDR_W-1:0] max_arr [NSP];
  logic [31:0]       rd_arr  [NSP];
  logic [CW-1:0]     cnt_q;
  logic              txn_we_q, txn_hit_q;
  logic [WA_W-1:0]   txn_word_q;

  genvar gi;
  generate
    for (gi = 0; gi < NSP; gi++) begin : g_space
      localparam int ID    = (gi == 0) ? SCAN_ID : AUX_ID;
      localparam int WORDS = (gi == 0) ? SCAN_WORDS : AUX_WORDS;
      assign cur_sel[gi] = (space_i == 16'(ID));
      assign in_rng[gi]  = (start_word < WA_W'(WORDS));
      assign max_arr[gi] = ADDR_W'((WORDS - 1) * 4);
      gw_word_mem #(.WORDS(WORDS), .WA_W(WA_W)) u_mem (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (done && txn_we_q && txn_hit_q && txn_sel_q[gi]),
        .word_addr (txn_word_q),
        .wdata     (wdata),
        .rdata     (rd_arr[gi])
      );
    end
  endgenerate

  always_comb begin
    space_ok  = |cur_sel;
    space_max = '0;
    rdata     = '0;
    for (int i = 0; i < NSP; i++) begin
      if (cur_sel[i])   space_max = max_arr[i];
      if (txn_sel_q[i]) rdata     = rd_arr[i];
    end
  end

  assign done = (cnt_q == CW'(1));
  assign hit  = txn_hit_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q      <= '0;
      txn_we_q   <= 1'b0;
      txn_hit_q  <= 1'b0;
      txn_sel_q  <= '0;
      txn_word_q <= '0;
    end else if (start) begin
      cnt_q      <= CW'(LAT);
      txn_we_q   <= start_we;
      txn_hit_q  <= |(cur_sel & in_rng);
      txn_sel_q  <= cur_sel;
      txn_word_q <= start_word;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - CW'(1);
    end
  end
endmodule

// File: rtl/cfg_gateway.sv
module cfg_gateway
  import cfg_gw_pkg::*;
#(
  parameter int LAT        = 4,
  parameter int SCAN_ID    = 7,
  parameter int SCAN_WORDS = 16,
  parameter int AUX_ID     = 2,
  parameter int AUX_WORDS  = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic        req_write,
  input  logic [7:0]  req_offset,
  input  logic [31:0] req_wdata,
  output logic        rsp_valid,
  output logic [31:0] rsp_rdata
);
  logic [15:0]       ctrl_space_q;
  logic [ADDR_W-1:0] addr_q;
  logic              flag_q, synd_q, busy_q, txn_we_q;
  logic [31:0]       data_q;

  logic wr_fire, rd_fire, ctrl_wr, addr_wr, data_wr, accept;
  logic [15:0]       look_space;
  logic              space_ok, done, hit;
  logic [ADDR_W-1:0] space_max;
  logic [31:0]       bank_rdata;

  assign req_ready = 1'b1;
  assign wr_fire = req_valid && req_ready && req_write;
  assign rd_fire = req_valid && req_ready && !req_write;
  assign ctrl_wr = wr_fire && !busy_q && (req_offset == OFS_CTRL);
  assign addr_wr = wr_fire && !busy_q && (req_offset == OFS_ADDR);
  assign data_wr = wr_fire && !busy_q && (req_offset == OFS_DATA);
  assign accept  = addr_wr && !req_wdata[SYND_BIT];
  assign look_space = ctrl_wr ? req_wdata[15:0] : ctrl_space_q;

  gw_space_bank #(
    .LAT(LAT), .SCAN_ID(SCAN_ID), .SCAN_WORDS(SCAN_WORDS),
    .AUX_ID(AUX_ID), .AUX_WORDS(AUX_WORDS)
  ) u_bank (
    .clk        (clk),
    .rst_n      (rst_n),
    .space_i    (look_space),
    .space_ok   (space_ok),
    .space_max  (space_max),
    .start      (accept),
    .start_we   (req_wdata[FLAG_BIT]),
    .start_word (req_wdata[ADDR_W-1:2]),
    .wdata      (data_q),
    .done       (done),
    .hit        (hit),
    .rdata      (bank_rdata)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_space_q <= '0;
      addr_q       <= '0;
      flag_q       <= 1'b0;
      synd_q       <= 1'b0;
      busy_q       <= 1'b0;
      txn_we_q     <= 1'b0;
      data_q       <= '0;
    end else if (busy_q) begin
      if (done) begin
        busy_q <= 1'b0;
        flag_q <= !txn_we_q;
        synd_q <= !hit;
        if (!txn_we_q) begin
          data_q <= hit ? bank_rdata : 32'h0;
          addr_q <= addr_q + ADDR_W'(4);
        end
      end
    end else if (ctrl_wr) begin
      ctrl_space_q <= req_wdata[15:0];
      addr_q       <= space_ok ? space_max : '0;
      flag_q       <= 1'b0;
      synd_q       <= 1'b0;
    end else if (accept) begin
      addr_q   <= req_wdata[ADDR_W-1:0];
      flag_q   <= req_wdata[FLAG_BIT];
      synd_q   <= 1'b0;
      busy_q   <= 1'b1;
      txn_we_q <= req_wdata[FLAG_BIT];
    end else if (data_wr) begin
      data_q <= req_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= rd_fire;
      if (rd_fire) begin
        case (req_offset)
          OFS_CTRL: rsp_rdata <= pack_ctrl(space_ok, ctrl_space_q);
          OFS_ADDR: rsp_rdata <= pack_addr(flag_q, synd_q, addr_q);
          OFS_DATA: rsp_rdata <= data_q;
          default:  rsp_rdata <= 32'h0;
        endcase
      end
    end
  end
endmodule

// File: rtl/cfg_gateway_chk.sv
module cfg_gateway_chk #(
  parameter int LAT = 4
) (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_write,
  input logic [7:0]  req_offset,
  input logic [31:0] req_wdata,
  input logic        rsp_valid,
  input logic        busy_q,
  input logic        done,
  input logic        txn_we_q,
  input logic        flag_q,
  input logic [29:0] addr_q,
  input logic [15:0] ctrl_space_q,
  input logic [31:0] data_q
);
  logic [15:0] cyc_q;
  always_ff @(posedge clk) begin
    if (!rst_n || !busy_q) cyc_q <= '0;
    else                   cyc_q <= cyc_q + 16'd1;
  end

  // R2
  rd_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |=> rsp_valid);
  // R2
  no_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && !req_write) |=> !rsp_valid);
  // R5
  bad_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && req_valid && req_write && req_offset == 8'h10 && req_wdata[30])
      |=> (!busy_q && $stable(addr_q)));
  // R6
  wr_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && done && txn_we_q) |=> (!flag_q && !busy_q));
  // R7
  rd_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && done && !txn_we_q) |=> (flag_q && addr_q == $past(addr_q) + 30'd4));
  // R6
  lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && done) |-> (cyc_q == 16'(LAT - 1)));
  // R9
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !done) |=> ($stable(flag_q) && $stable(ctrl_space_q) && $stable(data_q)));
endmodule

bind cfg_gateway cfg_gateway_chk #(.LAT(LAT)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_valid    (req_valid),
  .req_write    (req_write),
  .req_offset   (req_offset),
  .req_wdata    (req_wdata),
  .rsp_valid    (rsp_valid),
  .busy_q       (busy_q),
  .done         (done),
  .txn_we_q     (txn_we_q),
  .flag_q       (flag_q),
  .addr_q       (addr_q),
  .ctrl_space_q (ctrl_space_q),
  .data_q       (data_q)
);

// File: tb/cfg_gateway_tb.sv
module cfg_gateway_tb;
  localparam int LAT = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [7:0]  req_offset = '0;
  logic [31:0] req_wdata = '0;
  logic        req_ready, rsp_valid;
  logic [31:0] rsp_rdata;

  int errors = 0, checks = 0;

  always #5 clk = ~clk;

  cfg_gateway u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_offset(req_offset), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
  );

  // behavioural reference state
  logic [31:0] m_scan [16];
  logic [31:0] m_aux  [8];
  logic [15:0] m_space;
  logic [29:0] m_addr;
  logic        m_flag, m_synd, m_busy, m_we;
  logic [31:0] m_data;
  int          m_cnt;

  function automatic bit m_sup(input logic [15:0] s);
    return (s == 16'h7) || (s == 16'h2);
  endfunction
  function automatic int m_words(input logic [15:0] s);
    return (s == 16'h7) ? 16 : ((s == 16'h2) ? 8 : 0);
  endfunction

  function automatic logic [31:0] m_read(input logic [7:0] off);
    case (off)
      8'h04: return m_sup(m_space) ? {3'b001, 1'b1, 12'h0, m_space} : {16'h0, m_space};
      8'h10: return {m_flag, m_synd, m_addr};
      8'h14: return m_data;
      default: return 32'h0;
    endcase
  endfunction

  task automatic m_reset();
    for (int i = 0; i < 16; i++) m_scan[i] = '0;
    for (int i = 0; i < 8; i++)  m_aux[i]  = '0;
    m_space = '0; m_addr = '0; m_flag = 0; m_synd = 0;
    m_busy = 0; m_we = 0; m_data = '0; m_cnt = 0;
  endtask

  task automatic m_step(input bit v, input bit w, input logic [7:0] off, input logic [31:0] d);
    if (m_busy) begin
      if (m_cnt == 1) begin
        int wi = int'(m_addr >> 2);
        bit inr = m_sup(m_space) && (wi < m_words(m_space));
        m_busy = 0;
        m_synd = !inr;
        m_flag = !m_we;
        if (m_we) begin
          if (inr) begin
            if (m_space == 16'h7) m_scan[wi] = m_data; else m_aux[wi] = m_data;
          end
        end else begin
          m_data = inr ? ((m_space == 16'h7) ? m_scan[wi] : m_aux[wi]) : 32'h0;
          m_addr = m_addr + 30'd4;
        end
      end else m_cnt--;
    end else if (v && w) begin
      case (off)
        8'h04: begin
          m_space = d[15:0];
          m_addr = m_sup(d[15:0]) ? 30'((m_words(d[15:0]) - 1) * 4) : 30'd0;
          m_flag = 0; m_synd = 0;
        end
        8'h10: if (!d[30]) begin
          m_addr = d[29:0]; m_flag = d[31]; m_synd = 0;
          m_busy = 1; m_we = d[31]; m_cnt = LAT;
        end
        8'h14: m_data = d;
        default: ;
      endcase
    end
  endtask

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%08h expected=%08h at %0t", tag, act, exp, $time);
    end
  endtask

  // one clock: drive at negedge, compare response at the following negedge
  task automatic cyc(input bit v, input bit w, input logic [7:0] off, input logic [31:0] d,
                     input string tag);
    logic [31:0] exp_d;
    bit exp_v;
    req_valid = v; req_write = w; req_offset = off; req_wdata = d;
    exp_v = v && !w;
    exp_d = m_read(off);
    @(posedge clk);
    m_step(v, w, off, d);
    @(negedge clk);
    req_valid = 0;
    chk(rsp_valid == exp_v, {tag, " R2 rsp_valid"}, 32'(rsp_valid), 32'(exp_v));
    if (exp_v) chk(rsp_rdata == exp_d, tag, rsp_rdata, exp_d);
  endtask

  task automatic wreg(input logic [7:0] off, input logic [31:0] d, input string tag);
    cyc(1, 1, off, d, tag);
  endtask
  task automatic rreg(input logic [7:0] off, input string tag);
    cyc(1, 0, off, 32'h0, tag);
  endtask
  task automatic poll(input int n, input string tag);
    for (int i = 0; i < n; i++) rreg(8'h10, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    m_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk(req_ready == 1'b1, "R1 req_ready", 32'(req_ready), 32'h1);
    rreg(8'h04, "R1 ctrl");
    rreg(8'h10, "R1 addr");
    rreg(8'h14, "R1 data");
    rreg(8'h08, "R2 unmapped");
    wreg(8'h0c, 32'hFFFF_FFFF, "R2 unmapped write");
    rreg(8'h0c, "R2 unmapped");
    cyc(0, 0, 8'h0, 32'h0, "R2 idle");
    // R3 R4 select scan space
    wreg(8'h04, 32'hABCD_0007, "R3 select");
    rreg(8'h04, "R3 ctrl status");
    rreg(8'h10, "R4 max address");
    // R6 write access with flag polling
    wreg(8'h14, 32'hA5A5_0001, "R6 data");
    wreg(8'h10, 32'h8000_0008, "R6 start");
    poll(LAT + 1, "R6 flag");
    // R7 read back
    wreg(8'h10, 32'h0000_0008, "R7 start");
    poll(LAT + 1, "R7 flag/advance");
    rreg(8'h14, "R7 data");
    // R9 writes during busy ignored
    wreg(8'h10, 32'h0000_000C, "R9 start");
    wreg(8'h04, 32'h0000_0002, "R9 ctrl busy");
    wreg(8'h14, 32'h1111_1111, "R9 data busy");
    wreg(8'h10, 32'h8000_0000, "R9 addr busy");
    poll(LAT, "R9 flag");
    rreg(8'h04, "R9 ctrl kept");
    rreg(8'h14, "R9 data");
    // R5 bad address write ignored
    wreg(8'h10, 32'h4000_0004, "R5 bad");
    rreg(8'h10, "R5 addr kept");
    wreg(8'h10, 32'hC000_0004, "R5 bad flag");
    poll(2, "R5 addr kept");
    // R8 out of range
    wreg(8'h14, 32'hDEAD_BEEF, "R8 data");
    wreg(8'h10, 32'h8000_0040, "R8 oob write");
    poll(LAT + 1, "R8 synd");
    wreg(8'h10, 32'h0000_0040, "R8 oob read");
    poll(LAT + 1, "R8 synd/advance");
    rreg(8'h14, "R8 data zero");
    wreg(8'h10, 32'h0000_003C, "R8 synd clear");
    rreg(8'h10, "R8 synd clear");
    poll(LAT, "R8 last word");
    // R10 aux space independence
    wreg(8'h04, 32'h0000_0002, "R3 aux select");
    rreg(8'h04, "R3 aux ctrl");
    rreg(8'h10, "R4 aux max");
    wreg(8'h14, 32'h0000_1234, "R10 data");
    wreg(8'h10, 32'h8000_0008, "R10 aux write");
    poll(LAT, "R10 flag");
    wreg(8'h10, 32'h0000_0008, "R10 aux read");
    poll(LAT, "R10 flag");
    rreg(8'h14, "R10 aux data");
    wreg(8'h04, 32'h0000_0007, "R10 back to scan");
    wreg(8'h10, 32'h0000_0008, "R10 scan read");
    poll(LAT, "R10 flag");
    rreg(8'h14, "R10 scan data");
    // R3 R8 unsupported space
    wreg(8'h04, 32'h0000_0005, "R3 unsupported");
    rreg(8'h04, "R3 unsupported ctrl");
    rreg(8'h10, "R4 unsupported addr");
    wreg(8'h10, 32'h0000_0000, "R8 unsupported read");
    poll(LAT, "R8 unsupported");
    rreg(8'h14, "R8 unsupported data");
    // R6 R7 fill scan then chained scan
    wreg(8'h04, 32'h0000_0007, "R3 scan");
    for (int i = 0; i < 16; i++) begin
      wreg(8'h14, 32'h5000_0000 + 32'(i * 3), "R6 fill data");
      wreg(8'h10, 32'h8000_0000 | 32'(i * 4), "R6 fill");
      poll(LAT, "R6 fill flag");
    end
    wreg(8'h10, 32'h0000_0000, "R7 scan start");
    for (int i = 0; i < 16; i++) begin
      poll(LAT, "R7 scan flag");
      rreg(8'h14, "R7 scan data");
      wreg(8'h10, {2'b00, m_addr}, "R7 scan next");
    end
    poll(LAT, "R8 scan end");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule